// File: doc/BRIEF.md
# Nine-bit multiprocessor UART with wake-up filter

This block is a serial transceiver for a multidrop bus on which one master addresses several slaves. Every character on the wire carries nine data bits. The ninth bit is a tag. When it is 1, the low eight bits are a node select code. When it is 0, they are payload for the node that is currently selected. Line timing comes from an external clock enable, `tick16`, which pulses sixteen times per bit period. Both directions use this enable: the receiver samples each bit at its mid-point, and the transmitter holds each bit for sixteen ticks.

On the receive side, a host-writable wake-up bit controls which characters are delivered. While the bit is set, only select-code characters update the receive register and pulse `rx_irq`. Payload characters are dropped silently. The host reads each select code and compares it with its own node code. On a match it clears the wake-up bit, and from then on every well-framed character is delivered. A character whose stop bit reads low is counted as a framing error. It sets a sticky flag and is dropped.

The transmitter sends a nine-bit character when the host writes the data register. The ninth bit comes from a control bit, so a slave that has been selected can answer the master. The register port is plain: a write takes effect in the cycle it is presented, and there is no back-pressure. A data write that arrives while a character is still going out is discarded. Software is expected to wait for `tx_done` or for the busy status bit to clear before writing again.

Top module: `ninebit_mp_uart`

## Requirements
- R1: After a write to address 0, `txd` carries one character, with each bit lasting 16 ticks. The bits are, in order: a 0 start bit, `wr_data` bits 0 to 7 (least significant first), the control bit `txb8` (control register bit 1), and a 1 stop bit.
- R2: `tx_done` pulses high for one clock when the stop bit ends. Status bit 2 (busy) reads 1 from the write until that pulse and reads 0 afterwards. While idle, `txd` stays at 1.
- R3: A write to address 0 while busy is ignored: the character in flight is unchanged, and no second character follows it.
- R4: With wake (control bit 0) at 1, a received character whose ninth bit is 1 produces a one-clock `rx_irq` pulse. After that pulse, address 0 reads {ninth bit, data[7:0]} in bits 8..0.
- R5: With wake at 1, a received character whose ninth bit is 0 raises no `rx_irq` and leaves the address-0 read value unchanged.
- R6: With wake at 0, every character with a valid stop bit raises `rx_irq` and is stored, whatever its ninth bit.
- R7: A low pulse on `rxd` that is back high at the mid-point of the start bit is rejected. It causes no interrupt and no register change, and the next valid character is still received correctly.
- R8: A character whose stop bit samples low sets the framing-error flag (status bit 3), raises no `rx_irq` and leaves address 0 unchanged. Writing the control register with bit 2 at 1 clears the flag.
- R9: Out of reset, `txd` is 1, `rx_irq` and `tx_done` are 0, and both address 0 and address 1 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Clock enable at 16 times the bit rate |
| rxd | input | 1 | Serial receive line, idle high |
| txd | output | 1 | Serial transmit line, idle high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 = transmit data, 1 = control |
| wr_data | input | 8 | Write data; control bits: 0 wake, 1 txb8, 2 clear framing error |
| rd_addr | input | 2 | Read address: 0 = receive data, 1 = status |
| rd_data | output | 9 | Read data; status bits: 0 wake, 1 txb8, 2 busy, 3 framing error |
| rx_irq | output | 1 | One-clock pulse when a received character is delivered |
| tx_done | output | 1 | One-clock pulse when a transmitted stop bit completes |

## Verification
The assertions check a few rules on every cycle. While wake was set, any delivered character has its ninth bit at 1. A framing error never coincides with an interrupt. Both pulses last exactly one clock. The transmit line moves only on a tick while busy, it starts each character low, and it is idle high when done pulses. Only the bench scenarios can show the rest: that the serialised bit order and the ninth bit match the register contents, that a payload character is really dropped with the stored data untouched, that a start glitch leaves the receiver ready for the next character, and that a write made in the middle of a character has no effect on the wire.

// File: rtl/mpu_pkg.sv
package mpu_pkg;
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_WAITHI
  } rx_state_t;

  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;

  localparam int CTL_WAKE     = 0;
  localparam int CTL_TXB8     = 1;
  localparam int CTL_FERR_CLR = 2;
  localparam int STS_BUSY     = 2;
  localparam int STS_FERR     = 3;
endpackage

// File: rtl/mpu_sync.sv
module mpu_sync #(
  parameter int     STAGES    = 2,
  parameter logic   RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[s] <= RESET_VAL;
          else        pipe[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[s] <= RESET_VAL;
          else        pipe[s] <= pipe[s-1];
        end
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/mpu_rx.sv
module mpu_rx
  import mpu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            rxs,
  output logic            frame_ok,
  output logic            frame_err,
  output logic [DATA_W:0] word
);
  localparam int CW   = $clog2(OSR);
  localparam int FB   = DATA_W + 1;
  localparam int IW   = $clog2(FB + 1);
  localparam int HALF = OSR / 2 - 1;
  localparam int FULL = OSR - 1;

  rx_state_t         state;
  logic [CW-1:0]     cnt;
  logic [IW-1:0]     idx;
  logic [FB-1:0]     shreg;

  assign word = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= RX_IDLE;
      cnt       <= '0;
      idx       <= '0;
      shreg     <= '0;
      frame_ok  <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      frame_ok  <= 1'b0;
      frame_err <= 1'b0;
      case (state)
        RX_IDLE: begin
          cnt <= '0;
          if (tick && !rxs) state <= RX_START;
        end
        RX_START: if (tick) begin
          if (cnt == CW'(HALF)) begin
            cnt <= '0;
            idx <= '0;
            state <= rxs ? RX_IDLE : RX_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_DATA: if (tick) begin
          if (cnt == CW'(FULL)) begin
            cnt   <= '0;
            shreg <= {rxs, shreg[FB-1:1]};
            if (idx == IW'(FB - 1)) state <= RX_STOP;
            else                    idx   <= idx + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_STOP: if (tick) begin
          if (cnt == CW'(FULL)) begin
            cnt <= '0;
            if (rxs) frame_ok  <= 1'b1;
            else     frame_err <= 1'b1;
            state <= RX_WAITHI;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_WAITHI: if (rxs) state <= RX_IDLE;
        default: state <= RX_IDLE;
      endcase
    end
  end

  // R7: data phase is entered only if the line was still low at mid start bit
  a_r7_start_confirmed: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_DATA && $past(state) == RX_START) |-> !$past(rxs));

  // R8: a stop-bit verdict is only produced when leaving the stop phase
  a_r8_verdict_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok || frame_err) |-> (state == RX_WAITHI));
endmodule

// File: rtl/mpu_tx.sv
module mpu_tx #(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            load,
  input  logic [DATA_W:0] ld_data,
  output logic            txd,
  output logic            busy,
  output logic            done
);
  localparam int CW   = $clog2(OSR);
  localparam int FW   = DATA_W + 3;
  localparam int BW   = $clog2(FW + 1);
  localparam int FULL = OSR - 1;

  logic [FW-1:0] sh;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bitn;

  assign txd = busy ? sh[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '1;
      cnt  <= '0;
      bitn <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (load) begin
          busy <= 1'b1;
          sh   <= {1'b1, ld_data, 1'b0};
          cnt  <= '0;
          bitn <= '0;
        end
      end else if (tick) begin
        if (cnt == CW'(FULL)) begin
          cnt <= '0;
          sh  <= {1'b1, sh[FW-1:1]};
          if (bitn == BW'(FW - 1)) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            bitn <= bitn + 1'b1;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R1: every character opens with a low start bit
  a_r1_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);

  // R3: while busy the line only moves on a tick, so host writes cannot disturb it
  a_r3_line_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> ($stable(txd) || !busy));

  // R2: done pulses with the line idle high and the transmitter free
  a_r2_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && txd));

  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/ninebit_mp_uart.sv
module ninebit_mp_uart
  import mpu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16,
  parameter int SYNC   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick16,
  input  logic            rxd,
  output logic            txd,
  input  logic            wr_en,
  input  logic [1:0]      wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]      rd_addr,
  output logic [DATA_W:0] rd_data,
  output logic            rx_irq,
  output logic            tx_done
);
  logic            rxs;
  logic            frame_ok, frame_err;
  logic [DATA_W:0] rx_word;
  logic            busy;
  logic            wake, txb8, ferr;
  logic [DATA_W:0] rx_hold;
  logic            deliver, ctl_wr, tx_load;

  mpu_sync #(.STAGES(SYNC), .RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rxd), .q(rxs));

  mpu_rx #(.DATA_W(DATA_W), .OSR(OSR)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .rxs(rxs),
    .frame_ok(frame_ok), .frame_err(frame_err), .word(rx_word));

  assign tx_load = wr_en && (wr_addr == ADDR_DATA);
  assign ctl_wr  = wr_en && (wr_addr == ADDR_CTRL);

  mpu_tx #(.DATA_W(DATA_W), .OSR(OSR)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .load(tx_load),
    .ld_data({txb8, wr_data}), .txd(txd), .busy(busy), .done(tx_done));

  assign deliver = frame_ok && (!wake || rx_word[DATA_W]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake    <= 1'b0;
      txb8    <= 1'b0;
      ferr    <= 1'b0;
      rx_hold <= '0;
      rx_irq  <= 1'b0;
    end else begin
      rx_irq <= deliver;
      if (deliver) rx_hold <= rx_word;
      if (ctl_wr) begin
        wake <= wr_data[CTL_WAKE];
        txb8 <= wr_data[CTL_TXB8];
      end
      if (frame_err)                        ferr <= 1'b1;
      else if (ctl_wr && wr_data[CTL_FERR_CLR]) ferr <= 1'b0;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADDR_DATA: rd_data = rx_hold;
      ADDR_CTRL: begin
        rd_data[CTL_WAKE] = wake;
        rd_data[CTL_TXB8] = txb8;
        rd_data[STS_BUSY] = busy;
        rd_data[STS_FERR] = ferr;
      end
      default: rd_data = '0;
    endcase
  end

  // R5: with wake set, only select-code characters reach the host
  a_r5_wake_filter: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> (!$past(wake) || rx_hold[DATA_W]));

  // R8: a framing error is never announced as a delivered character
  a_r8_err_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ferr) |-> !rx_irq);

  // R4: the receive interrupt is a single-clock pulse
  a_r4_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |=> !rx_irq);
endmodule

// File: tb/sim_ninebit_mp_uart.sv
module sim_ninebit_mp_uart;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       rxd = 1'b1;
  logic       txd;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [1:0] rd_addr = 2'd0;
  logic [8:0] rd_data;
  logic       rx_irq, tx_done;

  int tests = 0;
  int fails = 0;
  int irq_cnt = 0;
  int done_cnt = 0;
  int tdiv = 0;
  bit finished = 0;

  localparam int BITCLK = 64;

  always #2 clk = ~clk;

  ninebit_mp_uart u0 (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd), .txd(txd),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .rx_irq(rx_irq), .tx_done(tx_done));

  always @(negedge clk) begin
    tdiv   <= (tdiv == 3) ? 0 : tdiv + 1;
    tick16 <= (tdiv == 3);
  end

  always @(posedge clk) begin
    if (rx_irq)  irq_cnt  <= irq_cnt + 1;
    if (tx_done) done_cnt <= done_cnt + 1;
  end

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int status_word(input bit wk, input bit b8, input bit bsy, input bit fe);
    return int'(wk) | (int'(b8) << 1) | (int'(bsy) << 2) | (int'(fe) << 3);
  endfunction

  function automatic bit delivers(input bit wk, input logic [8:0] f);
    return !wk || f[8];
  endfunction

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk);
    rd_addr = a;
    #1;
    v = int'(rd_data);
  endtask

  task automatic send_rx(input logic [8:0] f, input bit stop_hi);
    @(negedge clk);
    rxd = 1'b0;
    repeat (BITCLK) @(negedge clk);
    for (int i = 0; i < 9; i++) begin
      rxd = f[i];
      repeat (BITCLK) @(negedge clk);
    end
    rxd = stop_hi;
    repeat (BITCLK) @(negedge clk);
    rxd = 1'b1;
    repeat (96) @(negedge clk);
  endtask

  task automatic cap_tx(output logic [8:0] v, output bit ok);
    while (txd) @(negedge clk);
    repeat (BITCLK/2) @(negedge clk);
    ok = (txd == 1'b0);
    for (int i = 0; i < 9; i++) begin
      repeat (BITCLK) @(negedge clk);
      v[i] = txd;
    end
    repeat (BITCLK) @(negedge clk);
    ok = ok && (txd == 1'b1);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    int v, irq0, done0, lows;
    logic [8:0] f, hold, cap;
    bit ok, wk;
    void'($urandom(32'd20240611));

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9 reset state
    chk("R9 txd", int'(txd), 1);
    chk("R9 rx_irq", int'(rx_irq), 0);
    chk("R9 tx_done", int'(tx_done), 0);
    rd(2'd0, v); chk("R9 rx data", v, 0);
    rd(2'd1, v); chk("R9 status", v, 0);

    // R1/R2 directed transmit, txb8 = 1 then random
    for (int n = 0; n < 4; n++) begin
      bit b8;
      logic [7:0] d;
      b8 = (n == 0) ? 1'b1 : 1'($urandom);
      d  = (n == 0) ? 8'hA5 : 8'($urandom);
      wr(2'd1, {6'd0, b8, 1'b0});
      done0 = done_cnt;
      wr(2'd0, d);
      rd(2'd1, v); chk("R2 busy while sending", (v >> 2) & 1, 1);
      cap_tx(cap, ok);
      chk("R1 start/stop framing", int'(ok), 1);
      chk("R1 tx character", int'(cap), int'({b8, d}));
      repeat (BITCLK) @(negedge clk);
      chk("R2 one tx_done pulse", done_cnt - done0, 1);
      rd(2'd1, v); chk("R2 idle status", v, status_word(0, b8, 0, 0));
      chk("R2 idle line high", int'(txd), 1);
    end

    // R3 write while busy is ignored
    wr(2'd1, 8'h00);
    done0 = done_cnt;
    wr(2'd0, 8'h3C);
    fork
      cap_tx(cap, ok);
      begin
        repeat (200) @(negedge clk);
        wr(2'd0, 8'hC3);
      end
    join
    chk("R3 frame unchanged", int'(cap), 9'h03C);
    repeat (BITCLK) @(negedge clk);
    lows = 0;
    for (int i = 0; i < 800; i++) begin
      @(negedge clk);
      if (!txd) lows++;
    end
    chk("R3 no second frame", lows, 0);
    chk("R3 single done", done_cnt - done0, 1);

    // R4 select code accepted with wake set
    wr(2'd1, 8'h01);
    irq0 = irq_cnt;
    send_rx(9'h15A, 1'b1);
    chk("R4 irq on select code", irq_cnt - irq0, 1);
    rd(2'd0, v); chk("R4 rx data with bit8", v, 9'h15A);

    // R5 payload dropped with wake set
    irq0 = irq_cnt;
    send_rx(9'h0E7, 1'b1);
    chk("R5 no irq on payload", irq_cnt - irq0, 0);
    rd(2'd0, v); chk("R5 rx data unchanged", v, 9'h15A);

    // R6 wake cleared: payload and select both delivered
    wr(2'd1, 8'h00);
    irq0 = irq_cnt;
    send_rx(9'h0E7, 1'b1);
    chk("R6 irq payload", irq_cnt - irq0, 1);
    rd(2'd0, v); chk("R6 payload stored", v, 9'h0E7);
    irq0 = irq_cnt;
    send_rx(9'h1FF, 1'b1);
    chk("R6 irq select", irq_cnt - irq0, 1);
    rd(2'd0, v); chk("R6 select stored", v, 9'h1FF);

    // R7 start glitch
    irq0 = irq_cnt;
    @(negedge clk); rxd = 1'b0;
    repeat (16) @(negedge clk); rxd = 1'b1;
    repeat (2 * 11 * BITCLK) @(negedge clk);
    chk("R7 glitch no irq", irq_cnt - irq0, 0);
    rd(2'd0, v); chk("R7 glitch no change", v, 9'h1FF);
    send_rx(9'h081, 1'b1);
    chk("R7 recovers irq", irq_cnt - irq0, 1);
    rd(2'd0, v); chk("R7 recovers data", v, 9'h081);

    // R8 framing error
    irq0 = irq_cnt;
    send_rx(9'h142, 1'b0);
    chk("R8 no irq on bad stop", irq_cnt - irq0, 0);
    rd(2'd0, v); chk("R8 data unchanged", v, 9'h081);
    rd(2'd1, v); chk("R8 flag set", v, status_word(0, 0, 0, 1));
    wr(2'd1, 8'h04);
    rd(2'd1, v); chk("R8 flag cleared", v, status_word(0, 0, 0, 0));

    // R4/R5/R6 constrained random mix
    hold = 9'h081;
    for (int n = 0; n < 12; n++) begin
      wk = 1'($urandom);
      f  = 9'($urandom);
      wr(2'd1, {7'd0, wk});
      irq0 = irq_cnt;
      send_rx(f, 1'b1);
      if (delivers(wk, f)) hold = f;
      chk(wk ? "R5 random filter irq" : "R6 random open irq",
          irq_cnt - irq0, int'(delivers(wk, f)));
      rd(2'd0, v);
      chk(wk ? "R4 random data" : "R6 random data", v, int'(hold));
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule